// File: doc/BRIEF.md
# Sixteen-bit programmable pulse generator

This block makes a repeating two-level waveform from a 16-bit up-counter and two compare values. The counter is built from two 8-bit halves. The first compare value, the width, inverts the output flip-flop part of the way through each cycle. The second compare value, the period, inverts it again, clears the counter and raises a one-cycle interrupt. The level the flip-flop starts from is programmable, so the first phase can be high or low. An output pin always carries the inverse of the flip-flop.

Software reaches the block through a byte-wide write port with five addresses. Each 16-bit compare value is written as a low byte and then a high byte. The low byte waits in a holding latch, and both bytes reach the compare register together when the high byte is written. The compare registers have no shadow copy: a committed value is used on the next tick, even while the counter runs.

A control byte starts and stops the counter, carries the start level, and picks the tick source. The tick is the system clock divided by 8, 128 or 2048, or the rising edges of an external input after synchronisation.

Top module: `pulse_gen16`

## Requirements
- R1: After reset `pulse_ff` is 0, `pulse_pin_n` is 1 and `period_irq` is 0.
- R2: On each tick while running, the counter advances by one. When the advanced value equals the width value, `pulse_ff` inverts and counting continues, so the first phase after a start lasts exactly `width` ticks.
- R3: A tick that finds the counter equal to the period value clears the counter, inverts `pulse_ff` and drives `period_irq` high for exactly one clock cycle on that same edge. A full cycle is therefore period+1 ticks.
- R4: A control write made while the timer is stopped loads control bit 1 into `pulse_ff`. This gives positive or negative pulses.
- R5: `pulse_pin_n` is always the inverse of `pulse_ff`.
- R6: Write addresses are 0 width low, 1 width high, 2 period low, 3 period high and 4 control. A low-byte write only fills a holding latch and leaves the compare value unchanged. The high-byte write commits {high, held low} as one value.
- R7: A committed compare value is used by every tick after the edge that wrote the high byte, even while running.
- R8: While the timer is stopped, and when a control write arrives during running, `pulse_ff` holds its level. Control bit 1 is ignored unless the timer was already stopped. A stopped timer keeps its counter at zero, so each start counts from zero.
- R9: Control bit 0 is run and bits 3:2 select the tick: 0 is clock/8, 1 is clock/128, 2 is clock/2048, 3 is external. With divider D, the n-th tick after the start write edge W lands on edge W+n·D.
- R10: In external mode, a rising level on `ext_tick_in` first captured at edge X advances the counter at edge X+2. The input must hold each level for at least two clock cycles.
- R11: At clock/8 with width 0x07D0 and period 0x8002, the first phase lasts 2000 ticks (16000 clock cycles) of a 32771-tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick_in | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..4) |
| wr_data | input | 8 | Write data byte |
| pulse_ff | output | 1 | Output flip-flop level |
| pulse_pin_n | output | 1 | Inverted output pin |
| period_irq | output | 1 | One-cycle pulse at each period match |

## Verification
A wrong counter value or a stale compare register shows at the ports as a `pulse_ff` edge or a `period_irq` pulse landing on the wrong clock edge. The error appears within one tick of the fault, which is at most 2048 clock cycles at the slowest divider. A wrong holding latch or a lost start level shows on the first phase after the next start. A flip-flop that changes when it should hold shows at once as an edge for which no event was predicted. The bench predicts every edge down to the exact clock cycle, so an off-by-one in the compare, the prescaler phase or the synchroniser depth is caught on the first event it affects.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    // control byte bit positions
    localparam int CTL_RUN    = 0;
    localparam int CTL_LVL    = 1;
    localparam int CTL_SEL_LO = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_WID_LO = 3'd0,
        A_WID_HI = 3'd1,
        A_PER_LO = 3'd2,
        A_PER_HI = 3'd3,
        A_CTRL   = 3'd4
    } addr_e;

    typedef enum logic [1:0] {
        CS_DIV_A = 2'd0,
        CS_DIV_B = 2'd1,
        CS_DIV_C = 2'd2,
        CS_EXT   = 2'd3
    } clksel_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ff;
        logic             irq;
        logic             run;
        clksel_e          sel;
    } core_t;

endpackage

// File: rtl/pgen_pair_reg.sv
module pgen_pair_reg #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W-1:0]   din,
    output logic [2*W-1:0] val
);
    typedef struct packed {
        logic [W-1:0]   hold;
        logic [2*W-1:0] val;
    } pair_t;

    pair_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_lo) st_d.hold = din;
        if (wr_hi) st_d.val  = {din, st_q.hold};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;

    // R6
    commit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> val == {$past(din), $past(st_q.hold)});
    // R6
    lo_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(val));
endmodule

// File: rtl/pgen_edge_sync.sv
module pgen_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[1] & ~sh_q[2];

    // R10
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pgen_prescale.sv
module pgen_prescale
    import pgen_pkg::*;
#(
    parameter int unsigned TAP_A = 3,
    parameter int unsigned TAP_B = 7,
    parameter int unsigned TAP_C = 11
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run,
    input  clksel_e sel,
    input  logic    ext_rise,
    output logic    tick
);
    localparam int unsigned PRE_W = TAP_C;
    localparam int unsigned TAPS [3] = '{TAP_A, TAP_B, TAP_C};

    logic [PRE_W-1:0] pre_q, pre_d;
    logic [2:0]       hit;

    generate
        for (genvar g = 0; g < 3; g++) begin : g_tap
            localparam logic [PRE_W-1:0] MSK = PRE_W'((64'd1 << TAPS[g]) - 64'd1);
            assign hit[g] = ((pre_q & MSK) == MSK);
        end
    endgenerate

    always_comb begin
        pre_d = run ? pre_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    logic sel_hit;
    always_comb begin
        case (sel)
            CS_DIV_A: sel_hit = hit[0];
            CS_DIV_B: sel_hit = hit[1];
            CS_DIV_C: sel_hit = hit[2];
            default:  sel_hit = ext_rise;
        endcase
    end

    assign tick = run & sel_hit;

    // R9
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));
endmodule

// File: rtl/pulse_gen16.sv
module pulse_gen16
    import pgen_pkg::*;
#(
    parameter int unsigned TAP_A = 3,
    parameter int unsigned TAP_B = 7,
    parameter int unsigned TAP_C = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_tick_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              pulse_ff,
    output logic              pulse_pin_n,
    output logic              period_irq
);
    logic [CNT_W-1:0] wid_val, per_val, cnt_inc;
    logic             ext_rise, tick, ctl_wr;
    core_t            cur_q, nxt_d;

    assign ctl_wr = wr_en && (wr_addr == A_CTRL);

    pgen_pair_reg #(.W(BYTE_W)) u_wid (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && (wr_addr == A_WID_LO)),
        .wr_hi(wr_en && (wr_addr == A_WID_HI)),
        .din(wr_data), .val(wid_val)
    );

    pgen_pair_reg #(.W(BYTE_W)) u_per (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_en && (wr_addr == A_PER_LO)),
        .wr_hi(wr_en && (wr_addr == A_PER_HI)),
        .din(wr_data), .val(per_val)
    );

    pgen_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_tick_in), .rise(ext_rise)
    );

    pgen_prescale #(.TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(cur_q.run), .sel(cur_q.sel),
        .ext_rise(ext_rise), .tick(tick)
    );

    assign cnt_inc = cur_q.cnt + 1'b1;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.irq = 1'b0;
        if (ctl_wr) begin
            nxt_d.run = wr_data[CTL_RUN];
            nxt_d.sel = clksel_e'(wr_data[CTL_SEL_LO +: 2]);
            if (!cur_q.run) nxt_d.ff = wr_data[CTL_LVL];
        end
        if (!cur_q.run) begin
            nxt_d.cnt = '0;
        end else if (tick) begin
            if (cur_q.cnt == per_val) begin
                nxt_d.cnt = '0;
                nxt_d.ff  = ~cur_q.ff;
                nxt_d.irq = 1'b1;
            end else begin
                nxt_d.cnt = cnt_inc;
                if (cnt_inc == wid_val) nxt_d.ff = ~cur_q.ff;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pulse_ff    = cur_q.ff;
    assign pulse_pin_n = ~cur_q.ff;
    assign period_irq  = cur_q.irq;

    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |=> !period_irq);
    // R3
    irq_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> (cur_q.cnt == '0) && (pulse_ff != $past(pulse_ff)));
    // R8
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.run && !ctl_wr) |=> $stable(pulse_ff));
    // R8
    running_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.run && !tick) |=> $stable(pulse_ff));
    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.run && !tick && !ctl_wr) |=> $stable(cur_q.cnt));
endmodule

// File: tb/tb_pulse_gen16.sv
`timescale 1ns/1ps
module tb_pulse_gen16;
    localparam int K_TOG = 0;
    localparam int K_IRQ = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_tick_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pulse_ff, pulse_pin_n, period_irq;

    pulse_gen16 dut (
        .clk(clk), .rst_n(rst_n), .ext_tick_in(ext_tick_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pulse_ff(pulse_ff), .pulse_pin_n(pulse_pin_n), .period_irq(period_irq)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    kind;
        int    edge_c;
        string tag;
    } exp_t;

    exp_t exq[$];
    int   cyc = 0;
    int   nchk = 0;
    int   nerr = 0;
    logic mon_en = 1'b0;
    logic prev_ff = 1'b0;

    // reference model state
    int   mcnt = 0, mwid = 0, mper = 0;
    logic mlvl = 1'b0, mrun = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int k, input int e, input string tag);
        exp_t it;
        it.kind = k; it.edge_c = e; it.tag = tag;
        exq.push_back(it);
    endtask

    task automatic model_tick(input int e, input string tag);
        if (mcnt == mper) begin
            mcnt = 0; mlvl = ~mlvl;
            push(K_IRQ, e, tag); push(K_TOG, e, tag);
        end else begin
            mcnt = (mcnt + 1) % 65536;
            if (mcnt == mwid) begin mlvl = ~mlvl; push(K_TOG, e, tag); end
        end
    endtask

    task automatic seg(input int w, input int d, input int lo, input int hi, input string tag);
        for (int n = 1; w + n * d <= hi; n++)
            if (w + n * d > lo) model_tick(w + n * d, tag);
    endtask

    task automatic model_ctl(input int e, input logic lvl, input string tag);
        if (!mrun && lvl != mlvl) begin mlvl = lvl; push(K_TOG, e, tag); end
    endtask

    function automatic logic [7:0] ctl(input logic run, input logic lvl, input logic [1:0] sel);
        return {4'b0, sel, lvl, run};
    endfunction

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    // write captured exactly at edge e
    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d, input int e);
        wait_cyc(e - 1);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fail_line(input string tag, input string what, input int act, input int expv);
        nerr++;
        $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    endtask

    task automatic take(input int k);
        exp_t it;
        nchk++;
        if (exq.size() == 0) begin
            fail_line("R8", k == K_IRQ ? "unexpected irq at cycle" : "unexpected edge at cycle", cyc, -1);
        end else begin
            it = exq.pop_front();
            if (it.kind != k) fail_line(it.tag, "event kind", k, it.kind);
            else if (it.edge_c != cyc) fail_line(it.tag, "event cycle", cyc, it.edge_c);
        end
    endtask

    // monitor: pops expected events as the design produces them
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (period_irq) take(K_IRQ);
            if (pulse_ff !== prev_ff) take(K_TOG);
            prev_ff = pulse_ff;
        end
    end

    task automatic check_level(input string tag);
        repeat (3) @(negedge clk);
        nchk++;
        if (pulse_ff !== mlvl) fail_line(tag, "pulse_ff level", int'(pulse_ff), int'(mlvl));
        nchk++;
        // R5
        if (pulse_pin_n !== ~mlvl) fail_line("R5", "pin level", int'(pulse_pin_n), int'(~mlvl));
        nchk++;
        if (exq.size() != 0) fail_line(tag, "events not seen", exq.size(), 0);
        exq.delete();
    endtask

    task automatic set_regs(input int wid, input int per);
        int e;
        e = cyc + 2;
        bus_wr(3'd0, 8'(wid), e);
        bus_wr(3'd1, 8'(wid >> 8), e + 1);
        bus_wr(3'd2, 8'(per), e + 2);
        bus_wr(3'd3, 8'(per >> 8), e + 3);
        mwid = wid; mper = per;
    endtask

    // start at W, stop at S, predicted events pushed first
    task automatic run_phase(input logic [1:0] sel, input int d, input logic lvl,
                             input int span, input string tag);
        int w, s;
        w = cyc + 2; s = w + span;
        model_ctl(w, lvl, tag);
        mrun = 1'b1; mcnt = 0;
        seg(w, d, w, s, tag);
        mrun = 1'b0;
        bus_wr(3'd4, ctl(1'b1, lvl, sel), w);
        bus_wr(3'd4, ctl(1'b0, lvl, sel), s);
        check_level(tag);
    endtask

    initial begin : main
        int w, h, c, s, e;
        logic lv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        nchk++; if (pulse_ff !== 1'b0) fail_line("R1", "reset pulse_ff", int'(pulse_ff), 0);
        nchk++; if (pulse_pin_n !== 1'b1) fail_line("R1", "reset pin", int'(pulse_pin_n), 1);
        nchk++; if (period_irq !== 1'b0) fail_line("R1", "reset irq", int'(period_irq), 0);
        prev_ff = pulse_ff;
        mon_en = 1'b1;

        // R2 R3 R9: clock/8, positive pulses
        set_regs(3, 9);
        run_phase(2'd0, 8, 1'b0, 8 * 25 + 3, "R3");

        // R4: negative pulses at clock/128
        set_regs(2, 5);
        run_phase(2'd1, 128, 1'b1, 128 * 14 + 3, "R4");

        // R6: low byte alone leaves width at 2
        e = cyc + 2;
        bus_wr(3'd0, 8'd4, e);
        run_phase(2'd0, 8, 1'b0, 8 * 12 + 3, "R6");

        // R7 R8: live period change, control write while running, stop
        set_regs(4, 20);
        w = cyc + 2; h = w + 243; c = w + 323; s = w + 483;
        model_ctl(w, 1'b0, "R7");
        mrun = 1'b1; mcnt = 0;
        seg(w, 8, w, h, "R7");
        mper = 12;
        seg(w, 8, h, c, "R7");
        lv = ~mlvl;
        seg(w, 8, c, s, "R8");
        mrun = 1'b0;
        bus_wr(3'd4, ctl(1'b1, 1'b0, 2'd0), w);
        bus_wr(3'd2, 8'd12, h - 1);
        bus_wr(3'd3, 8'd0, h);
        bus_wr(3'd4, ctl(1'b1, lv, 2'd0), c);
        bus_wr(3'd4, ctl(1'b0, ~mlvl, 2'd0), s);
        check_level("R8");
        // R4: load while stopped
        e = cyc + 2;
        lv = ~mlvl;
        model_ctl(e, lv, "R4");
        bus_wr(3'd4, ctl(1'b0, lv, 2'd0), e);
        check_level("R4");

        // R9: clock/2048
        set_regs(1, 2);
        run_phase(2'd2, 2048, 1'b0, 2048 * 7 + 3, "R9");

        // R10: external ticks, rise every 4 cycles
        set_regs(2, 4);
        w = cyc + 2; s = w + 4 * 12 + 6;
        model_ctl(w, 1'b0, "R10");
        mrun = 1'b1; mcnt = 0;
        for (int i = 0; i < 12; i++) model_tick(w + 4 * i + 4, "R10");
        mrun = 1'b0;
        bus_wr(3'd4, ctl(1'b1, 1'b0, 2'd3), w);
        for (int i = 0; i < 12; i++) begin
            wait_cyc(w + 4 * i + 1); ext_tick_in = 1'b1;
            wait_cyc(w + 4 * i + 3); ext_tick_in = 1'b0;
        end
        bus_wr(3'd4, ctl(1'b0, 1'b0, 2'd3), s);
        check_level("R10");

        // R11: 2000-tick first phase
        set_regs(16'h07D0, 16'h8002);
        run_phase(2'd0, 8, 1'b0, 8 * 2000 + 5, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule